// File: doc/BRIEF.md
# Three-channel linked-descriptor DMA engine

This block is a bus-master DMA controller. It feeds three downstream video sinks from byte buffers held in host memory. Each channel follows its own chain of descriptors. A descriptor is four 32-bit words in memory. The engine reads each descriptor's length and buffer base and fetches the payload one byte at a time through a read master that uses a valid/ready handshake. Each payload byte leaves on a byte stream tagged with the number of the channel that produced it.

Work is scheduled by a periodic service tick. On each tick the engine visits channel 0, then 1, then 2. Each running channel moves one burst of at most a fixed number of bytes. When a descriptor is used up, the engine reads the descriptor's link word and flags word. It then either moves to the next descriptor or ends the chain. Software drives each channel through three registers: a request register, a staged descriptor-address register, and a running register. A global status register shows whether any channel is still running. Software polls that register after it stops the channels.

Top module: `desc_dma_engine`

## Requirements
- R1: After reset, every channel is stopped. Each running register and the status register read 0, and no memory request or output byte is issued.
- R2: A write to a channel's descriptor-address register (base+4) only stages an address. Nothing moves until a later write of 1 to the request register (base+0). The staged address survives until that write.
- R3: A write of 1 to the request register sets the channel running. If the staged address is non-zero, it also becomes the current descriptor, progress returns to 0 and the staged address is cleared. If the staged address is zero, the channel resumes at its current descriptor and progress.
- R4: A descriptor at address D holds four words: the link at D+0, the byte length at D+4, the buffer base at D+8 and the flags at D+12. Payload bytes are read at buffer base plus progress and emitted in that order, one per byte response. Each byte response carries its byte in data bits 7:0.
- R5: Per tick, a running channel emits at most 128 bytes: the smaller of 128 and the bytes left in the descriptor. On every service the engine reads the length word and the base word again. A single-descriptor transfer of L bytes therefore costs 2*ceil(L/128)+2 word reads.
- R6: When progress reaches the length, the link word becomes the current descriptor and progress clears. A link with bit 0 set ends the chain and stops the channel. An even link continues the chain at the next tick.
- R7: Bit 24 of the flags word ends the chain even when the link word is even.
- R8: A service round starts only on a tick, once every 64 cycles by default. Ticks that arrive while a round is still running collapse into one pending tick. Within a round, channels are served in the order 0, 1, 2.
- R9: Channel c's registers sit at 0x50+0x10*c. Writing any value other than 1 to the request register, or writing 0 to the running register (base+8), clears running. Reading base+8 returns the running bit in bit 0. A burst already in flight completes, but no further bursts follow.
- R10: Bit 4 of the status register at 0xB4 reads 1 while any channel is running and 0 once all have stopped.
- R11: A channel that is running but whose current descriptor address has bit 0 set is marked stopped at its next service. No memory access is made for it.
- R12: A memory request holds its address while valid is high and ready is low. The engine waits for each response, however long it is delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_req_word | output | 1 | 1 = 32-bit word read, 0 = single byte read |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data (byte reads use bits 7:0) |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_chan | output | 2 | Channel that produced the byte |

## Verification
The bench runs against a memory model that holds back ready and delays responses. A design that assumed a fixed latency would return shifted or repeated bytes. Transfers of 5, 128, 129 and 300 bytes are checked for data and for their count of word reads. A cap or burst-split error shows up as a wrong count or as lost bytes at the 128-byte boundary. Both end conditions are tested: an odd link, and the flag bit with an even link. An engine that ignored the flag would wander into the next descriptor. The bench stops a channel in the middle of a transfer and then requests it again with no staged address. An engine that cleared progress on every request would replay the start of the buffer. The bench times its request writes against a tick. It then checks that the three channels' bursts interleave 0, 1, 2, 0, 1, 2. It also checks that an odd staged address stops the channel without any memory traffic.

// File: rtl/dde_pkg.sv
package dde_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_CHECK,
    SQ_LEN_REQ, SQ_LEN_WAIT,
    SQ_BUF_REQ, SQ_BUF_WAIT,
    SQ_BYTE_REQ, SQ_BYTE_WAIT,
    SQ_NXT_REQ, SQ_NXT_WAIT,
    SQ_FLG_REQ, SQ_FLG_WAIT,
    SQ_NEXT_CH
  } seq_state_t;

  // word offsets inside a descriptor
  localparam int unsigned OFS_LINK  = 0;
  localparam int unsigned OFS_LEN   = 4;
  localparam int unsigned OFS_BASE  = 8;
  localparam int unsigned OFS_FLAGS = 12;
  localparam int unsigned LAST_BIT  = 24;

  // bytes to move in one service: remaining bytes, capped
  function automatic logic [31:0] burst_bytes(input logic [31:0] len,
                                              input logic [31:0] prog,
                                              input int unsigned cap);
    logic [31:0] left;
    if (prog >= len) return 32'd0;
    left = len - prog;
    if (left > 32'(cap)) return 32'(cap);
    return left;
  endfunction

  // a chain continues only when both end markers are clear
  function automatic logic chain_goes_on(input logic [31:0] link,
                                         input logic [31:0] flags);
    return !link[0] && !flags[LAST_BIT];
  endfunction

endpackage

// File: rtl/dde_tick.sv
module dde_tick #(
  parameter int unsigned TICK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic pending
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(TICK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)      pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dde_chan_regs.sv
module dde_chan_regs #(
  parameter int unsigned NCH        = 3,
  parameter int unsigned REG_AW     = 8,
  parameter int unsigned REG_BASE   = 'h50,
  parameter int unsigned REG_STRIDE = 'h10,
  parameter int unsigned STAT_ADDR  = 'hB4,
  parameter int unsigned BUSY_BIT   = 4,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CHW-1:0]    eng_ch,
  input  logic              eng_stop,
  input  logic              eng_inc,
  input  logic              eng_adv,
  input  logic [31:0]       eng_next,
  input  logic              eng_keep,
  output logic [NCH-1:0]    run_vec,
  output logic [31:0]       cur_addr [NCH],
  output logic [31:0]       prog     [NCH]
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [REG_AW-1:0] A_REQ  = REG_AW'(REG_BASE + c * REG_STRIDE);
    localparam logic [REG_AW-1:0] A_DESC = REG_AW'(REG_BASE + c * REG_STRIDE + 4);
    localparam logic [REG_AW-1:0] A_RUN  = REG_AW'(REG_BASE + c * REG_STRIDE + 8);

    logic        run_q;
    logic [31:0] cur_q, prog_q, stage_q;
    logic        mine, wr_req, wr_desc, wr_run, req_one;

    assign mine    = (eng_ch == CHW'(c));
    assign wr_req  = reg_we && (reg_addr == A_REQ);
    assign wr_desc = reg_we && (reg_addr == A_DESC);
    assign wr_run  = reg_we && (reg_addr == A_RUN);
    assign req_one = (reg_wdata == 32'd1);

    // engine updates first, software writes override them
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q   <= 1'b0;
        cur_q   <= '0;
        prog_q  <= '0;
        stage_q <= '0;
      end else begin
        if (mine && eng_stop) run_q  <= 1'b0;
        if (mine && eng_inc)  prog_q <= prog_q + 32'd1;
        if (mine && eng_adv) begin
          cur_q  <= eng_next;
          prog_q <= '0;
          run_q  <= eng_keep;
        end
        if (wr_req) begin
          run_q <= req_one;
          if (req_one && (stage_q != '0)) begin
            cur_q   <= stage_q;
            prog_q  <= '0;
            stage_q <= '0;
          end
        end
        if (wr_desc) stage_q <= reg_wdata;
        if (wr_run && (reg_wdata == '0)) run_q <= 1'b0;
      end
    end

    assign run_vec[c]  = run_q;
    assign cur_addr[c] = cur_q;
    assign prog[c]     = prog_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(STAT_ADDR)) reg_rdata[BUSY_BIT] = |run_vec;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == REG_AW'(REG_BASE + c * REG_STRIDE + 8))
        reg_rdata = {31'd0, run_vec[c]};
    end
  end
endmodule

// File: rtl/dde_sequencer.sv
module dde_sequencer
  import dde_pkg::*;
#(
  parameter int unsigned NCH       = 3,
  parameter int unsigned MAX_BURST = 128,
  localparam int unsigned CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned CNTW = $clog2(MAX_BURST + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_pending,
  output logic           tick_take,
  input  logic [NCH-1:0] run_vec,
  input  logic [31:0]    cur_addr [NCH],
  input  logic [31:0]    prog     [NCH],
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [31:0]    mem_req_addr,
  output logic           mem_req_word,
  input  logic           mem_rsp_valid,
  input  logic [31:0]    mem_rsp_data,
  output logic [CHW-1:0] eng_ch,
  output logic           eng_stop,
  output logic           eng_inc,
  output logic           eng_adv,
  output logic [31:0]    eng_next,
  output logic           eng_keep,
  output logic           chan_start,
  output logic           out_valid,
  output logic [7:0]     out_data,
  output logic [CHW-1:0] out_chan
);

  seq_state_t      state_q;
  logic [CHW-1:0]  ch_q;
  logic [31:0]     len_q, base_q, link_q;
  logic [CNTW-1:0] cnt_q;

  logic [31:0] cur_sel, prog_sel, burst_now;
  logic        run_sel, last_ch;

  assign cur_sel   = cur_addr[ch_q];
  assign prog_sel  = prog[ch_q];
  assign run_sel   = run_vec[ch_q];
  assign last_ch   = (ch_q == CHW'(NCH - 1));
  assign burst_now = burst_bytes(len_q, prog_sel, MAX_BURST);

  assign tick_take  = (state_q == SQ_IDLE) && tick_pending;
  assign eng_ch     = ch_q;
  assign eng_stop   = (state_q == SQ_CHECK) && (!run_sel || cur_sel[0]);
  assign chan_start = (state_q == SQ_CHECK) && run_sel && !cur_sel[0];
  assign eng_inc    = (state_q == SQ_BYTE_WAIT) && mem_rsp_valid;
  assign eng_adv    = (state_q == SQ_FLG_WAIT) && mem_rsp_valid && run_sel;
  assign eng_next   = link_q;
  assign eng_keep   = chain_goes_on(link_q, mem_rsp_data);

  always_comb begin
    mem_req_valid = 1'b1;
    mem_req_word  = 1'b1;
    mem_req_addr  = cur_sel;
    unique case (state_q)
      SQ_LEN_REQ:  mem_req_addr = cur_sel + 32'(OFS_LEN);
      SQ_BUF_REQ:  mem_req_addr = cur_sel + 32'(OFS_BASE);
      SQ_NXT_REQ:  mem_req_addr = cur_sel + 32'(OFS_LINK);
      SQ_FLG_REQ:  mem_req_addr = cur_sel + 32'(OFS_FLAGS);
      SQ_BYTE_REQ: begin
        mem_req_addr = base_q + prog_sel;
        mem_req_word = 1'b0;
      end
      default:     mem_req_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      ch_q      <= '0;
      len_q     <= '0;
      base_q    <= '0;
      link_q    <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= eng_inc;
      if (eng_inc) begin
        out_data <= mem_rsp_data[7:0];
        out_chan <= ch_q;
      end
      unique case (state_q)
        SQ_IDLE: if (tick_pending) begin
          ch_q    <= '0;
          state_q <= SQ_CHECK;
        end
        SQ_CHECK:    state_q <= eng_stop ? SQ_NEXT_CH : SQ_LEN_REQ;
        SQ_LEN_REQ:  if (mem_req_ready) state_q <= SQ_LEN_WAIT;
        SQ_LEN_WAIT: if (mem_rsp_valid) begin
          len_q   <= mem_rsp_data;
          state_q <= SQ_BUF_REQ;
        end
        SQ_BUF_REQ:  if (mem_req_ready) state_q <= SQ_BUF_WAIT;
        SQ_BUF_WAIT: if (mem_rsp_valid) begin
          base_q <= mem_rsp_data;
          if (burst_bytes(len_q, prog_sel, MAX_BURST) == '0) begin
            state_q <= SQ_NEXT_CH;
          end else begin
            cnt_q   <= CNTW'(burst_now);
            state_q <= SQ_BYTE_REQ;
          end
        end
        SQ_BYTE_REQ: if (mem_req_ready) state_q <= SQ_BYTE_WAIT;
        SQ_BYTE_WAIT: if (mem_rsp_valid) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNTW'(1)) begin
            if ((prog_sel + 32'd1 >= len_q) && run_sel) state_q <= SQ_NXT_REQ;
            else                                        state_q <= SQ_NEXT_CH;
          end else begin
            state_q <= SQ_BYTE_REQ;
          end
        end
        SQ_NXT_REQ:  if (mem_req_ready) state_q <= SQ_NXT_WAIT;
        SQ_NXT_WAIT: if (mem_rsp_valid) begin
          link_q  <= mem_rsp_data;
          state_q <= SQ_FLG_REQ;
        end
        SQ_FLG_REQ:  if (mem_req_ready) state_q <= SQ_FLG_WAIT;
        SQ_FLG_WAIT: if (mem_rsp_valid) state_q <= SQ_NEXT_CH;
        SQ_NEXT_CH: begin
          if (last_ch) begin
            state_q <= SQ_IDLE;
          end else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= SQ_CHECK;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine #(
  parameter int unsigned NCH         = 3,
  parameter int unsigned TICK_CYCLES = 64,
  parameter int unsigned MAX_BURST   = 128,
  parameter int unsigned REG_AW      = 8,
  parameter int unsigned REG_BASE    = 'h50,
  parameter int unsigned REG_STRIDE  = 'h10,
  parameter int unsigned STAT_ADDR   = 'hB4,
  parameter int unsigned BUSY_BIT    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [31:0]              mem_req_addr,
  output logic                     mem_req_word,
  input  logic                     mem_rsp_valid,
  input  logic [31:0]              mem_rsp_data,
  output logic                     out_valid,
  output logic [7:0]               out_data,
  output logic [$clog2(NCH)-1:0]   out_chan
);
  localparam int unsigned CHW = $clog2(NCH);

  logic           tick_pending, tick_take;
  logic [NCH-1:0] run_vec;
  logic [31:0]    cur_addr [NCH];
  logic [31:0]    prog     [NCH];
  logic [CHW-1:0] eng_ch;
  logic           eng_stop, eng_inc, eng_adv, eng_keep, chan_start;
  logic [31:0]    eng_next;

  dde_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .take(tick_take), .pending(tick_pending)
  );

  dde_chan_regs #(
    .NCH(NCH), .REG_AW(REG_AW), .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE),
    .STAT_ADDR(STAT_ADDR), .BUSY_BIT(BUSY_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_ch(eng_ch), .eng_stop(eng_stop), .eng_inc(eng_inc), .eng_adv(eng_adv),
    .eng_next(eng_next), .eng_keep(eng_keep),
    .run_vec(run_vec), .cur_addr(cur_addr), .prog(prog)
  );

  dde_sequencer #(.NCH(NCH), .MAX_BURST(MAX_BURST)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tick_pending(tick_pending), .tick_take(tick_take),
    .run_vec(run_vec), .cur_addr(cur_addr), .prog(prog),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_word(mem_req_word),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .eng_ch(eng_ch), .eng_stop(eng_stop), .eng_inc(eng_inc), .eng_adv(eng_adv),
    .eng_next(eng_next), .eng_keep(eng_keep), .chan_start(chan_start),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan)
  );
endmodule

// File: rtl/dde_checker.sv
module dde_checker #(
  parameter int unsigned NCH        = 3,
  parameter int unsigned MAX_BURST  = 128,
  parameter int unsigned REG_AW     = 8,
  parameter int unsigned REG_BASE   = 'h50,
  parameter int unsigned REG_STRIDE = 'h10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_we,
  input logic [REG_AW-1:0]      reg_addr,
  input logic [31:0]            reg_wdata,
  input logic                   mem_req_valid,
  input logic                   mem_req_ready,
  input logic [31:0]            mem_req_addr,
  input logic                   mem_rsp_valid,
  input logic                   out_valid,
  input logic [$clog2(NCH)-1:0] out_chan,
  input logic [NCH-1:0]         run_vec,
  input logic                   chan_start
);
  logic [15:0] beats_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          beats_q <= '0;
    else if (chan_start) beats_q <= '0;
    else if (out_valid)  beats_q <= beats_q + 16'd1;
  end

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (beats_q < 16'(MAX_BURST)));                                    // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R12

  AST_BYTE_FROM_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mem_rsp_valid));                                            // R4

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_chan) < NCH));                                           // R8

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == REG_AW'(REG_BASE + c * REG_STRIDE) && reg_wdata == 32'd1)
        |=> run_vec[c]);                                                            // R3
    AST_REQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == REG_AW'(REG_BASE + c * REG_STRIDE) && reg_wdata != 32'd1)
        |=> !run_vec[c]);                                                           // R9
    AST_RUN_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == REG_AW'(REG_BASE + c * REG_STRIDE + 8) && reg_wdata == 32'd0)
        |=> !run_vec[c]);                                                           // R9
  end
endmodule

bind desc_dma_engine dde_checker #(
  .NCH(NCH), .MAX_BURST(MAX_BURST), .REG_AW(REG_AW),
  .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .out_valid(out_valid), .out_chan(out_chan),
  .run_vec(run_vec), .chan_start(chan_start)
);

// File: tb/desc_dma_engine_bench.sv
module desc_dma_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_word;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic [1:0]  out_chan;

  desc_dma_engine u_desc_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_word(mem_req_word),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int word_reads = 0, byte_reads = 0;
  logic [31:0] mem [0:1023];
  int          log_n = 0;
  logic [7:0]  log_d [0:4095];
  logic [1:0]  log_c [0:4095];

  // len, buffer base, end kind (1 = flag bit 24 with even link, 0 = odd link)
  localparam logic [32:0] VEC [0:3] = '{
    {16'd5,   16'h0800, 1'b1},
    {16'd128, 16'h0803, 1'b0},
    {16'd129, 16'h0901, 1'b1},
    {16'd300, 16'h0A02, 1'b0}
  };

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) ^ (a >> 5));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int at, input logic [31:0] link, len, base, flags);
    mem[at/4]     = link;
    mem[at/4 + 1] = len;
    mem[at/4 + 2] = base;
    mem[at/4 + 3] = flags;
  endtask

  task automatic wr(input int ch, input int ofs, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'('h50 + 16 * ch + ofs); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic wait_stop(input int ch);
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(8'('h58 + 16 * ch), d);
      if (d[0] == 1'b0) break;
    end
    repeat (20) @(negedge clk);
  endtask

  // compare the bytes of channel ch logged from index s against bufA/bufB
  task automatic chk_stream(input int ch, input int s, input int bufa, input int lena,
                            input int bufb, input int lenb, input string tag);
    int n = 0, bad = 0;
    logic [7:0] e;
    for (int i = s; i < log_n; i++) begin
      if (int'(log_c[i]) == ch) begin
        e = (n < lena) ? pat(bufa + n) : pat(bufb + n - lena);
        if (log_d[i] != e) bad++;
        n++;
      end
    end
    chk(n == lena + lenb, {tag, " byte count"}, n, lena + lenb);
    chk(bad == 0, {tag, " byte values"}, bad, 0);
  endtask

  // memory model: ready held back on some requests, response after 1 or 2 cycles
  initial begin
    bit busy = 0, stall = 0, is_word = 0;
    int waitn = 0, nreq = 0;
    logic [31:0] a = '0, w;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        busy = 1; waitn = nreq % 2;
      end else if (busy) begin
        if (waitn == 0) begin
          w = mem[(a >> 2) & 32'h3FF];
          mem_rsp_valid = 1'b1;
          mem_rsp_data = is_word ? w : {24'hC3C3C3, 8'(w >> (8 * a[1:0]))};
          busy = 0;
        end else waitn--;
      end else if (rst_n && mem_req_valid) begin
        if (stall) stall = 0;
        else begin
          mem_req_ready = 1'b1;
          a = mem_req_addr; is_word = mem_req_word;
          if (is_word) word_reads++; else byte_reads++;
          nreq++;
          stall = (nreq % 3 == 0);
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && log_n < 4096) begin
      log_d[log_n] = out_data; log_c[log_n] = out_chan; log_n++;
    end
  end

  initial forever begin
    @(posedge clk);
    if (rst_n) cyc++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s, w0, n1;
    for (int i = 0; i < 1024; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};

    // R1: reset state
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_req_valid == 1'b0, "R1 no memory request", mem_req_valid, 0);
    for (int c = 0; c < 3; c++) begin
      rd(8'('h58 + 16 * c), d);
      chk(d == 0, "R1 running reg", d, 0);
    end
    rd(8'hB4, d);
    chk(d == 0, "R1 status reg", d, 0);

    // vector table on channel 0: R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      int len = int'(VEC[v][32:17]);
      int bsa = int'(VEC[v][16:1]);
      bit kind = VEC[v][0];
      int exp_words = 2 * ((len + 127) / 128) + 2;
      put_desc('h10, kind ? 32'h50 : 32'h51, 32'(len), 32'(bsa), kind ? 32'h0100_0000 : 32'h0);
      s = log_n; w0 = word_reads;
      wr(0, 4, 32'h10);
      wr(0, 0, 32'd1);
      wait_stop(0);
      chk_stream(0, s, bsa, len, 0, 0, kind ? "R7 flag end" : "R6 odd link end");
      chk(word_reads - w0 == exp_words, "R5 word reads per transfer", word_reads - w0, exp_words);
    end

    // R6 two-descriptor chain on channel 1 (also R12 under stalled memory)
    put_desc('h20, 32'h30, 32'd10, 32'h900, 32'h0);
    put_desc('h30, 32'h41, 32'd7,  32'hA00, 32'h0);
    s = log_n;
    wr(1, 4, 32'h20);
    wr(1, 0, 32'd1);
    wait_stop(1);
    chk_stream(1, s, 'h900, 10, 'hA00, 7, "R6 chain follow");

    // R11: odd current descriptor stops without memory traffic
    w0 = word_reads + byte_reads;
    wr(1, 4, 32'h41);
    wr(1, 0, 32'd1);
    rd(8'h68, d);
    chk(d[0] == 1'b1, "R11 running right after request", d[0], 1);
    repeat (140) @(negedge clk);
    rd(8'h68, d);
    chk(d[0] == 1'b0, "R11 stopped at service", d[0], 0);
    chk(word_reads + byte_reads == w0, "R11 no memory access", word_reads + byte_reads - w0, 0);

    // R2: staged address alone moves nothing
    put_desc('h60, 32'h1, 32'd600, 32'h400, 32'h0);
    s = log_n;
    wr(2, 4, 32'h60);
    repeat (200) @(negedge clk);
    chk(log_n == s, "R2 no bytes before request", log_n - s, 0);
    rd(8'h78, d);
    chk(d[0] == 1'b0, "R2 running stays 0", d[0], 0);

    // R9: running register write 0 stops channel 2 (staged address survived, R2)
    wr(2, 0, 32'd1);
    while (log_n - s < 20) @(negedge clk);
    wr(2, 8, 32'd0);
    rd(8'h78, d);
    chk(d[0] == 1'b0, "R9 running reg write 0", d[0], 0);
    repeat (1000) @(negedge clk);
    n1 = log_n;
    repeat (400) @(negedge clk);
    chk(log_n == n1, "R9 no bytes after stop", log_n - n1, 0);
    chk(n1 - s < 600, "R9 stopped before end", n1 - s, 599);

    // R9 + R3 + R10: stop by request write 2, resume with empty staging
    put_desc('h80, 32'h1, 32'd1000, 32'h400, 32'h0);
    s = log_n;
    wr(0, 4, 32'h80);
    wr(0, 0, 32'd1);
    rd(8'hB4, d);
    chk(d[4] == 1'b1, "R10 busy while running", d[4], 1);
    while (log_n - s < 50) @(negedge clk);
    wr(0, 0, 32'd2);
    rd(8'h58, d);
    chk(d[0] == 1'b0, "R9 request write 2 stops", d[0], 0);
    repeat (1000) @(negedge clk);
    n1 = log_n;
    repeat (400) @(negedge clk);
    chk(log_n == n1 && n1 - s < 1000, "R9 stream halted mid descriptor", n1 - s, 0);
    wr(0, 0, 32'd1);
    wait_stop(0);
    chk_stream(0, s, 'h400, 1000, 0, 0, "R3 resume keeps progress");
    rd(8'hB4, d);
    chk(d[4] == 1'b0, "R10 idle after all stop", d[4], 0);

    // R8: requests placed just after a tick, bursts interleave 0,1,2,0,1,2
    put_desc('hA0, 32'h1, 32'd256, 32'h100, 32'h0100_0000);
    put_desc('hB0, 32'h1, 32'd256, 32'h200, 32'h0100_0000);
    put_desc('hC0, 32'h1, 32'd256, 32'h300, 32'h0100_0000);
    wr(0, 4, 32'hA0); wr(1, 4, 32'hB0); wr(2, 4, 32'hC0);
    while ((cyc % TICK) != 20) @(negedge clk);
    s = log_n;
    wr(0, 0, 32'd1); wr(1, 0, 32'd1); wr(2, 0, 32'd1);
    wait_stop(0); wait_stop(1); wait_stop(2);
    begin
      int segs = 0, badseg = 0, prev = -1;
      for (int i = s; i < log_n; i++) begin
        if (int'(log_c[i]) != prev) begin
          if (int'(log_c[i]) != segs % 3) badseg++;
          prev = int'(log_c[i]);
          segs++;
        end
      end
      chk(segs == 6, "R8 burst segment count", segs, 6);
      chk(badseg == 0, "R8 round order", badseg, 0);
    end
    chk_stream(0, s, 'h100, 256, 0, 0, "R8 ch0 data");
    chk_stream(2, s, 'h300, 256, 0, 0, "R8 ch2 data");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule